// File: doc/BRIEF.md
# Dual-Channel DAC Input Aligner

This block sits between a sample source and a two-channel digital-to-analogue converter. In split mode, two 16-bit sample streams arrive on separate valid/ready inputs, one per DAC channel, with no timing relation between them. Each stream is written into its own FIFO. The block takes a read only when both FIFOs hold at least one sample. It then pops one word from each FIFO in the same cycle, so the two DAC channels always receive matched pairs, however the inputs drift.

In packed mode, the sender presents both channels at once on the A input, with the A sample on `a_data` and the B sample on `b_data`. One wider FIFO stores the pair as a single word, and the block drains it whenever it is not empty. Changing the mode pin empties both FIFOs.

Back-pressure works as follows. A channel's `*_ready` output is high while its FIFO has room and low when the FIFO is full or while a flush is in progress. A sample is accepted on any edge where valid and ready are both high. If a sender holds valid high while its FIFO is full, that sample is discarded and the channel's overflow flag is set. A sample offered during a flush cycle is lost without setting the flag.

Top module: `dac_pair_aligner`

## Requirements
- R1: In split mode, channel A and channel B each buffer up to DEPTH samples (default 256) in their own FIFO. A channel's ready output stays high while its FIFO holds fewer than DEPTH samples, whatever the other channel's fill level.
- R2: In split mode, a read takes one sample from each FIFO in the same cycle, and only when both are non-empty. The pair is registered onto `dac_a`/`dac_b`, and `pair_valid` is high for the one cycle after the read edge.
- R3: Samples leave each FIFO in the order they were accepted, and simultaneous write and read in one cycle lose nothing.
- R4: `rd_active` is high exactly in the cycles in which a read is taken, one cycle ahead of the matching `pair_valid`.
- R5: In a cycle with no read, `dac_a` and `dac_b` keep their previous values and `pair_valid` is low.
- R6: A full FIFO drives its ready low. A valid sample offered while full is discarded and sets that channel's overflow flag, which stays set until reset.
- R7: With `packed_mode`=1, the A input carries both channels: `a_data` goes to `dac_a` and `b_data` goes to `dac_b`, from one FIFO that is read whenever it is not empty. In this mode `b_ready` is 0, and `b_valid` has no effect and never sets `ovf_b`.
- R8: In the first cycle after `packed_mode` changes, both FIFOs are emptied, no read is taken and both readies are low. Samples buffered before the change never reach the outputs.
- R9: Reset (asynchronous, active low) empties both FIFOs, clears `dac_a`, `dac_b`, `pair_valid` and both overflow flags, and selects split mode internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| packed_mode | input | 1 | 0: two separate 16-bit streams; 1: one 32-bit stream on the A input |
| a_valid | input | 1 | Channel A sample (or packed pair) offered |
| a_ready | output | 1 | Channel A FIFO can accept |
| a_data | input | 16 | Channel A sample; packed mode: channel A half |
| b_valid | input | 1 | Channel B sample offered (split mode only) |
| b_ready | output | 1 | Channel B FIFO can accept |
| b_data | input | 16 | Channel B sample; packed mode: channel B half, qualified by `a_valid` |
| dac_a | output | 16 | Registered channel A DAC word |
| dac_b | output | 16 | Registered channel B DAC word |
| pair_valid | output | 1 | New pair present on `dac_a`/`dac_b` |
| rd_active | output | 1 | A FIFO read is taken this cycle |
| ovf_a | output | 1 | Sticky: channel A sample discarded while full |
| ovf_b | output | 1 | Sticky: channel B sample discarded while full |

## Verification
Two pairs of functions can land on the same edge.

The first pair is a write and a read on the same FIFO. The bench provokes this by streaming both channels back to back. It judges the result by the exact order and count of pairs that emerge, with none skipped or repeated.

The second pair is a rejected write on a full FIFO and the later draining of that FIFO. The bench fills channel A to its limit while channel B is empty, then offers one more sample. It then feeds channel B and checks three things: the overflow flag rises, exactly DEPTH pairs come out in order, and the rejected sample never appears.

A mode change that arrives while data is buffered is judged by `pair_valid` staying low across the flush and the following cycles.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_PACKED = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/dpa_fifo.sv
module dpa_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign rd_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never exceeds the configured depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  // R3: a read is never taken from an empty store
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  // R6: the controller never writes into a full store
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/dpa_out_stage.sv
module dpa_out_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] dac_a,
  output logic [W-1:0] dac_b,
  output logic         pair_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_a      <= '0;
      dac_b      <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= load;
      if (load) begin
        dac_a <= a_in;
        dac_b <= b_in;
      end
    end
  end

  // R2: a read edge yields a strobe in the following cycle
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pair_valid);
  // R5: without a read the outputs hold and the strobe is low
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dac_a) && $stable(dac_b) && !pair_valid));
endmodule

// File: rtl/dac_pair_aligner.sv
module dac_pair_aligner #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DEPTH    = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                packed_mode,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [SAMPLE_W-1:0] a_data,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic [SAMPLE_W-1:0] b_data,
  output logic [SAMPLE_W-1:0] dac_a,
  output logic [SAMPLE_W-1:0] dac_b,
  output logic                pair_valid,
  output logic                rd_active,
  output logic                ovf_a,
  output logic                ovf_b
);
  import dpa_pkg::*;

  localparam int unsigned WIDE_W = 2 * SAMPLE_W;
  localparam int unsigned CW     = $clog2(DEPTH + 1);

  pack_mode_e mode_q, mode_now;
  logic       flush, wide;

  logic [WIDE_W-1:0]   f0_wdata, f0_rdata;
  logic [SAMPLE_W-1:0] f1_rdata;
  logic [CW-1:0]       cnt0, cnt1;
  logic                full0, full1, empty0, empty1;
  logic                wr0, wr1, pop0, pop1;
  logic [SAMPLE_W-1:0] out_a, out_b;

  assign mode_now = pack_mode_e'(packed_mode);
  assign flush    = (mode_now != mode_q);
  assign wide     = (mode_now == MODE_PACKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SPLIT;
    else        mode_q <= mode_now;
  end

  // back-pressure and acceptance
  assign a_ready = !full0 && !flush;
  assign b_ready = !full1 && !flush && !wide;
  assign wr0     = a_valid && a_ready;
  assign wr1     = b_valid && b_ready;
  assign f0_wdata = wide ? {b_data, a_data} : {{SAMPLE_W{1'b0}}, a_data};

  // paired read decision
  assign pop0      = !flush && !empty0 && (wide || !empty1);
  assign pop1      = pop0 && !wide;
  assign rd_active = pop0;

  assign out_a = f0_rdata[SAMPLE_W-1:0];
  assign out_b = wide ? f0_rdata[WIDE_W-1:SAMPLE_W] : f1_rdata;

  // sticky discard flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_a <= 1'b0;
      ovf_b <= 1'b0;
    end else begin
      if (a_valid && full0 && !flush)          ovf_a <= 1'b1;
      if (b_valid && full1 && !flush && !wide) ovf_b <= 1'b1;
    end
  end

  dpa_fifo #(.W(WIDE_W), .DEPTH(DEPTH)) u_fifo_a (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr0), .wr_data(f0_wdata),
    .rd_en(pop0), .rd_data(f0_rdata),
    .count(cnt0), .full(full0), .empty(empty0)
  );

  dpa_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo_b (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr1), .wr_data(b_data),
    .rd_en(pop1), .rd_data(f1_rdata),
    .count(cnt1), .full(full1), .empty(empty1)
  );

  dpa_out_stage #(.W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(pop0),
    .a_in(out_a), .b_in(out_b),
    .dac_a(dac_a), .dac_b(dac_b), .pair_valid(pair_valid)
  );

  // R2: a split-mode read needs a sample waiting on channel B too
  p_pair_needs_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && !packed_mode) |-> (cnt1 != '0));
  // R6: overflow flags are sticky
  p_sticky_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |=> ovf_a);
  p_sticky_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_b |=> ovf_b);
  // R7: packed mode closes the B input
  p_wide_b_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    packed_mode |-> !b_ready);
  // R8: a flush leaves both stores empty and produces no pair
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt0 == '0 && cnt1 == '0 && !pair_valid));
endmodule

// File: tb/tb_dac_pair_aligner.sv
module tb_dac_pair_aligner;
  localparam int DEPTH = 256;
  localparam time CLK_P = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        packed_mode = 1'b0;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic        a_ready, b_ready, pair_valid, rd_active, ovf_a, ovf_b;
  logic [15:0] dac_a, dac_b;

  int checks = 0;
  int errs   = 0;

  always #(CLK_P / 2) clk = ~clk;

  dac_pair_aligner #(.SAMPLE_W(16), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .packed_mode(packed_mode),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .dac_a(dac_a), .dac_b(dac_b), .pair_valid(pair_valid),
    .rd_active(rd_active), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  typedef struct packed {
    logic        av;
    logic [15:0] ad;
    logic        bv;
    logic [15:0] bd;
    logic        pv;
    logic [15:0] ea;
    logic [15:0] eb;
    logic        ra;
  } vec_t;

  // split mode, sampled just after each edge
  localparam vec_t VT [10] = '{
    '{1'b1, 16'h1111, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 16'h2222, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 16'hB001, 1'b0, 16'h0000, 16'h0000, 1'b1},
    '{1'b0, 16'h0000, 1'b1, 16'hB002, 1'b1, 16'h1111, 16'hB001, 1'b1},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h2222, 16'hB002, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h2222, 16'hB002, 1'b0},
    '{1'b1, 16'h3333, 1'b1, 16'hB003, 1'b0, 16'h2222, 16'hB002, 1'b1},
    '{1'b1, 16'h4444, 1'b1, 16'hB004, 1'b1, 16'h3333, 16'hB003, 1'b1},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h4444, 16'hB004, 1'b0},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h4444, 16'hB004, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic av, input logic [15:0] ad,
                      input logic bv, input logic [15:0] bd);
    @(negedge clk);
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int idx;
    int bad;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "pair_valid in reset", 32'(pair_valid), 32'd0);
    chk("R9", "dac pair in reset", {dac_a, dac_b}, 32'd0);
    chk("R9", "ovf flags in reset", {30'd0, ovf_a, ovf_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "readies after reset", {30'd0, a_ready, b_ready}, 32'd3);

    // R2 R3 R4 R5: vector table in split mode
    for (int i = 0; i < 10; i++) begin
      step(VT[i].av, VT[i].ad, VT[i].bv, VT[i].bd);
      chk("R2", $sformatf("row %0d pair_valid", i), 32'(pair_valid), 32'(VT[i].pv));
      chk("R3", $sformatf("row %0d dac pair", i), {dac_a, dac_b}, {VT[i].ea, VT[i].eb});
      chk("R4", $sformatf("row %0d rd_active", i), 32'(rd_active), 32'(VT[i].ra));
    end

    // R1 R6: fill channel A with B empty
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 16'h5000 + 16'(i), 1'b0, 16'h0);
      if (pair_valid) bad++;
      if (i == DEPTH - 2) chk("R1", "a_ready one below full", 32'(a_ready), 32'd1);
    end
    chk("R2", "no pair while B empty", 32'(bad), 32'd0);
    chk("R6", "a_ready when full", 32'(a_ready), 32'd0);
    chk("R1", "b_ready independent of A", 32'(b_ready), 32'd1);
    chk("R6", "ovf_a before discard", 32'(ovf_a), 32'd0);
    step(1'b1, 16'hDEAD, 1'b0, 16'h0);
    chk("R6", "ovf_a after discard", 32'(ovf_a), 32'd1);
    chk("R6", "ovf_b untouched", 32'(ovf_b), 32'd0);

    // R3: drain by feeding B; write and read share edges
    idx = 0;
    bad = 0;
    for (int i = 0; i < DEPTH + 20 && idx < DEPTH; i++) begin
      if (i < DEPTH) step(1'b0, 16'h0, 1'b1, 16'h6000 + 16'(i));
      else           step(1'b0, 16'h0, 1'b0, 16'h0);
      if (pair_valid) begin
        if (dac_a !== 16'h5000 + 16'(idx) || dac_b !== 16'h6000 + 16'(idx)) bad++;
        idx++;
      end
    end
    chk("R3", "pairs emitted", 32'(idx), 32'(DEPTH));
    chk("R3", "pairs out of order", 32'(bad), 32'd0);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R5", "idle strobe", 32'(pair_valid), 32'd0);
    chk("R5", "idle hold", {dac_a, dac_b}, {16'h50FF, 16'h60FF});
    chk("R6", "ovf_a sticky", 32'(ovf_a), 32'd1);
    chk("R1", "a_ready after drain", 32'(a_ready), 32'd1);

    // R8: stale A data dropped by switch to packed
    for (int i = 0; i < 3; i++) step(1'b1, 16'h7001 + 16'(i), 1'b0, 16'h0);
    @(negedge clk);
    packed_mode = 1'b1;
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R8", "no read during flush", 32'(rd_active), 32'd0);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R8", "stale data discarded", 32'(pair_valid), 32'd0);

    // R7: packed mode
    step(1'b1, 16'h1234, 1'b1, 16'hABCD);
    chk("R7", "b_ready in packed", 32'(b_ready), 32'd0);
    step(1'b1, 16'h5678, 1'b1, 16'h9ABC);
    chk("R7", "first packed pair", {15'd0, pair_valid, dac_a}, {16'd1, 16'h1234});
    chk("R7", "first packed hi", 32'(dac_b), 32'hABCD);
    step(1'b0, 16'h0, 1'b1, 16'h0BAD);
    chk("R7", "second packed pair", {dac_a, dac_b}, {16'h5678, 16'h9ABC});
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R7", "b_valid ignored", {30'd0, pair_valid, ovf_b}, 32'd0);

    // R8: buffered packed word dropped on return to split
    step(1'b1, 16'h4242, 1'b0, 16'h2424);
    @(negedge clk);
    packed_mode = 1'b0;
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R8", "flush blocks read", 32'(pair_valid), 32'd0);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R8", "packed leftover gone", 32'(pair_valid), 32'd0);
    step(1'b1, 16'h0A0A, 1'b1, 16'h0B0B);
    step(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R8", "split pair after return", {dac_a, dac_b}, {16'h0A0A, 16'h0B0B});

    // R9: reset clears sticky flag and outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "reset clears ovf and outputs", {14'd0, ovf_a, pair_valid, dac_a}, 32'd0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule